// File: doc/BRIEF.md
# Aliased Miscellaneous Control Register

This block is a register-bus slave around one 64-bit control and status word. Only the sixteen most significant bits of that word are kept in flops, and the lower 48 bits always read as zero. Software reaches the word through three consecutive word addresses. One overwrites it, one sets bits by OR-ing the write data in, and a third either ANDs the write data in or wipes the word. A build-time parameter picks that third behaviour together with the base address.

The most significant bit of the stored word drives a level interrupt toward an interrupt controller. Software raises it through the overwrite or set alias and drops it through the overwrite or third alias. The bus port is synchronous. It carries a word address (byte address shifted right by three, so every access is a full 8-byte word; bit 63 is the most significant bit of the big-endian word), 64-bit write data, and registered read data with a one-cycle valid pulse.

Top module: `misc_reg_alias`

## Requirements
- R1: After reset the stored word is zero, `irq_o` is low, and `rvalid_o` and `rdata_o` are zero.
- R2: A write to the overwrite alias (word offset 0x4020 when VARIANT=0, 0x6080 when VARIANT=1) stores the write data. A later read of that alias returns the stored value.
- R3: A write to the set alias (base + 2: 0x4022 or 0x6082) stores the current value OR the write data.
- R4: Every update result is masked to bits 63..48 before it is stored, so bits 47..0 of any read data are zero.
- R5: A write to base + 1 (0x4021 or 0x6081) stores the current value AND the write data when VARIANT=0. When VARIANT=1 it stores zero whatever the write data is.
- R6: A read of any word offset other than the overwrite alias returns zero. This includes base + 1, base + 2 and unmapped offsets.
- R7: A write to any offset outside base .. base + 2 leaves the stored word and `irq_o` unchanged.
- R8: `rvalid_o` is high exactly in the cycle after each cycle with `rd_en_i` high, and `rdata_o` is valid in that cycle. A read and a write in the same cycle return the value held before the write.
- R9: `irq_o` equals bit 63 of the stored word. It changes only in the cycle after a write to one of the three aliases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address (byte address >> 3) |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after `rd_en_i` |
| irq_o | output | 1 | Level interrupt, bit 63 of the stored word |

## Verification
The assertions check on every cycle that the read-valid pulse tracks the read strobe and that the low 48 bits of returned data stay zero. They also check that reads of non-overwrite offsets return zero and that the interrupt moves only after an alias write. For the overwrite, set and third aliases they check the direction the interrupt must take, and they check that a plain read's top bit agrees with the interrupt. Full-word values after chains of OR, AND and clear updates need the bench's scenarios. So do the read-before-write ordering and the effect of one variant's offsets on the other variant, because the bench drives both variants from the same bus.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_THIRD = 2'd2,
    OP_SET   = 2'd3
  } upd_op_e;

  localparam int unsigned VAR_AND   = 0;
  localparam int unsigned VAR_CLEAR = 1;

  function automatic int unsigned base_word(input int unsigned variant);
    return (variant == VAR_CLEAR) ? 32'h6080 : 32'h4020;
  endfunction
endpackage

// File: rtl/misc_reg_dec.sv
module misc_reg_dec
  import misc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned VARIANT = VAR_AND
) (
  input  logic [ADDR_W-1:0] addr_i,
  output upd_op_e           op_o,
  output logic              plain_o
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(base_word(VARIANT));

  always_comb begin
    op_o = OP_NONE;
    if (addr_i == BASE)                    op_o = OP_LOAD;
    else if (addr_i == BASE + ADDR_W'(1))  op_o = OP_THIRD;
    else if (addr_i == BASE + ADDR_W'(2))  op_o = OP_SET;
  end

  assign plain_o = (addr_i == BASE);
endmodule

// File: rtl/misc_reg_upd.sv
module misc_reg_upd
  import misc_reg_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned KEEP_W  = 16,
  parameter int unsigned VARIANT = VAR_AND
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  upd_op_e           op_i,
  output logic [DATA_W-1:0] nxt_o
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W;
  localparam logic [DATA_W-1:0] MASK = {{KEEP_W{1'b1}}, {LOW_W{1'b0}}};

  logic [DATA_W-1:0] third;
  logic [DATA_W-1:0] raw;

  generate
    if (VARIANT == VAR_CLEAR) begin : g_clear
      assign third = '0;
    end else begin : g_and
      assign third = cur_i & wdata_i;
    end
  endgenerate

  always_comb begin
    case (op_i)
      OP_LOAD:  raw = wdata_i;
      OP_THIRD: raw = third;
      OP_SET:   raw = cur_i | wdata_i;
      default:  raw = cur_i;
    endcase
    nxt_o = raw & MASK;  // mask after the operation
  end
endmodule

// File: rtl/misc_reg_alias.sv
module misc_reg_alias
  import misc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned KEEP_W  = 16,
  parameter int unsigned VARIANT = VAR_AND
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  upd_op_e           op;
  logic              plain_hit;
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              irq_q;

  misc_reg_dec #(
    .ADDR_W (ADDR_W),
    .VARIANT(VARIANT)
  ) dec_i (
    .addr_i (addr_i),
    .op_o   (op),
    .plain_o(plain_hit)
  );

  misc_reg_upd #(
    .DATA_W (DATA_W),
    .KEEP_W (KEEP_W),
    .VARIANT(VARIANT)
  ) upd_i (
    .cur_i  (reg_q),
    .wdata_i(wdata_i),
    .op_i   (op),
    .nxt_o  (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q    <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      rdata_q  <= (rd_en_i && plain_hit) ? reg_q : '0;  // pre-write value
      if (wr_en_i && op != OP_NONE) begin
        reg_q <= nxt;
        irq_q <= nxt[DATA_W-1];
      end
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/misc_reg_alias_chk.sv
module misc_reg_alias_chk
  import misc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned KEEP_W  = 16,
  parameter int unsigned VARIANT = VAR_AND
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              irq_o
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W;
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(base_word(VARIANT));
  localparam logic [ADDR_W-1:0] A_THIRD = A_LOAD + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET   = A_LOAD + ADDR_W'(2);

  logic mapped;
  assign mapped = (addr_i == A_LOAD) || (addr_i == A_THIRD) || (addr_i == A_SET);

  AST_RVALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);  // R8
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);  // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[LOW_W-1:0] == '0));  // R4
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != A_LOAD) |=> (rdata_o == '0));  // R6
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && mapped) |=> $stable(irq_o));  // R7
  AST_LOAD_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_LOAD) |=> (irq_o == $past(wdata_i[DATA_W-1])));  // R2
  AST_SET_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SET && wdata_i[DATA_W-1]) |=> irq_o);  // R3
  AST_READ_MATCHES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && addr_i == A_LOAD) |=> (rdata_o[DATA_W-1] == irq_o));  // R9

  generate
    if (VARIANT == VAR_CLEAR) begin : g_clear
      AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_THIRD) |=> !irq_o);  // R5
    end else begin : g_and
      AST_AND_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_THIRD && !wdata_i[DATA_W-1]) |=> !irq_o);  // R5
    end
  endgenerate
endmodule

bind misc_reg_alias misc_reg_alias_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .KEEP_W (KEEP_W),
  .VARIANT(VARIANT)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .rvalid_o(rvalid_o),
  .irq_o   (irq_o)
);

// File: tb/misc_reg_alias_tb_top.sv
module misc_reg_alias_tb_top;
  localparam int unsigned AW = 17;
  localparam int unsigned DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr  = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_a, rdata_b;
  logic          rvalid_a, rvalid_b, irq_a, irq_b;

  misc_reg_alias #(.ADDR_W(AW), .DATA_W(DW), .KEEP_W(16), .VARIANT(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_a), .rvalid_o(rvalid_a), .irq_o(irq_a));

  misc_reg_alias #(.ADDR_W(AW), .DATA_W(DW), .KEEP_W(16), .VARIANT(1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_b), .rvalid_o(rvalid_b), .irq_o(irq_b));

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] ma = '0;
  logic [15:0] mb = '0;
  logic [63:0] qa[$];
  logic [63:0] qb[$];
  string       qt[$];

  function automatic logic [15:0] mupd(input int v, input logic [15:0] cur,
                                       input logic [AW-1:0] a, input logic [63:0] d);
    logic [AW-1:0] b;
    b = (v == 1) ? 17'h6080 : 17'h4020;
    if (a == b)      return d[63:48];
    if (a == b + 1)  return (v == 1) ? 16'h0 : (cur & d[63:48]);
    if (a == b + 2)  return cur | d[63:48];
    return cur;
  endfunction

  function automatic logic [63:0] mrd(input int v, input logic [15:0] cur, input logic [AW-1:0] a);
    logic [AW-1:0] b;
    b = (v == 1) ? 17'h6080 : 17'h4020;
    return (a == b) ? {cur, 48'h0} : 64'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input bit rd, input logic [AW-1:0] a,
                       input logic [63:0] d, input string tag);
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    @(posedge clk);
    if (rd) begin
      qa.push_back(mrd(0, ma, a));
      qb.push_back(mrd(1, mb, a));
      qt.push_back(tag);
    end
    if (wr) begin
      ma = mupd(0, ma, a, d);
      mb = mupd(1, mb, a, d);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  // monitor: scoreboard pops on each read-valid, irq tracked every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rvalid_a || rvalid_b) begin
        if (qa.size() == 0) begin
          chk("R8 unexpected rvalid", 64'(rvalid_a), 64'd0);
        end else begin
          string t;
          logic [63:0] ea, eb;
          ea = qa.pop_front(); eb = qb.pop_front(); t = qt.pop_front();
          chk({t, " varA"}, rdata_a, ea);
          chk({t, " varB"}, rdata_b, eb);
          chk("R8 rvalid pair", 64'(rvalid_b), 64'(rvalid_a));
        end
      end
      chk("R9 irq varA", 64'(irq_a), 64'(ma[15]));
      chk("R9 irq varB", 64'(irq_b), 64'(mb[15]));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata_a | rdata_b, 64'h0);
    chk("R1 reset rvalid", 64'(rvalid_a | rvalid_b), 64'h0);
    chk("R1 reset irq", 64'(irq_a | irq_b), 64'h0);
    rst_n = 1'b1;
    drive(0, 1, 17'h4020, '0, "R1 read after reset");
    drive(0, 1, 17'h6080, '0, "R1 read after reset");
    drive(1, 0, 17'h4020, 64'h1234_5678_9ABC_DEF0, "R2");
    drive(0, 1, 17'h4020, '0, "R2 R4 load readback");
    drive(1, 0, 17'h4020, 64'h8000_FFFF_FFFF_FFFF, "R9");
    drive(0, 1, 17'h4020, '0, "R9 R4 msb load");
    drive(1, 0, 17'h4022, 64'h0F00_0000_0000_0001, "R3");
    drive(0, 1, 17'h4020, '0, "R3 set alias varA");
    drive(1, 0, 17'h4021, 64'h7FF0_FFFF_FFFF_FFFF, "R5");
    drive(0, 1, 17'h4020, '0, "R5 and alias varA");
    drive(0, 1, 17'h4021, '0, "R6 read third alias");
    drive(0, 1, 17'h4022, '0, "R6 read set alias");
    drive(1, 0, 17'h6080, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    drive(0, 1, 17'h6080, '0, "R2 R7 load varB only");
    drive(1, 0, 17'h6081, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    drive(0, 1, 17'h6080, '0, "R5 clear alias varB");
    drive(1, 0, 17'h6082, 64'h8001_0000_0000_0000, "R3");
    drive(0, 1, 17'h6080, '0, "R3 set alias varB");
    drive(1, 0, 17'h4023, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    drive(1, 0, 17'h6079, 64'h0000_0000_0000_0000, "R7");
    drive(0, 1, 17'h4020, '0, "R7 unmapped write varA");
    drive(0, 1, 17'h6080, '0, "R7 unmapped write varB");
    drive(0, 1, 17'h1234, '0, "R6 read unmapped");
    idle(2);
    drive(1, 1, 17'h4020, 64'hA5A5_0000_0000_0000, "R8 read before write");
    drive(0, 1, 17'h4020, '0, "R8 value after write");
    drive(1, 0, 17'h4021, 64'h0000_FFFF_FFFF_FFFF, "R5");
    drive(0, 1, 17'h4020, '0, "R5 and clears msb");
    idle(4);
    chk("R8 scoreboard drained", 64'(qa.size()), 64'd0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule